// File: doc/BRIEF.md
# Adjustable-Increment Time-of-Day Counter

This block keeps a time-of-day count, in seconds and nanoseconds, in one clock domain with a nominal 125 MHz clock. On every cycle the count advances by a base step of 8 ns plus a signed fractional trim. The trim is given in units of 2^-32 ns. A 32-bit fractional accumulator collects the trim, and each time it overflows or underflows, that cycle's step becomes 9 ns or 7 ns. The clock source is never retuned: frequency correction exists only as a change in the average step. The nanosecond field wraps at one billion and carries into the seconds field.

Software loads a new time through a one-cycle write strobe. The write sets both fields together and clears the fractional accumulator. A one-cycle read strobe copies both fields into a holding register, so software always gets a coherent pair.

A pulse generator raises its output on each boundary of a programmable period. Boundaries are counted from the start of each second, so the period must divide one billion. The output rises in the cycle after the counter reaches or passes a boundary, which places every edge on a clock edge. The high time is a programmable number of cycles. A width of zero selects half the period. When the trim is nonzero, successive edges move between neighbouring cycles.

The pulse generator is a four-state machine:
- **PS_IDLE**: the generator is off and the output is low.
- **PS_SEEK**: the generator steps a target boundary forward, one period per cycle, starting from the start of the current second. It stops once the target lies beyond the current time.
- **PS_WAIT**: the output is low and the generator waits for the count to reach the target.
- **PS_HIGH**: the output is high and a countdown runs for the width.

The transitions are:
- *arm* (IDLE→SEEK): enable is raised.
- *aligned* (SEEK→WAIT): the target is ahead of the current time.
- *fire* (WAIT→HIGH): the count reaches the target, and the target advances by one period.
- *expire* (HIGH→WAIT): the countdown ends.
- *retrigger* (HIGH→HIGH): a boundary arrives while the output is still high.
- *realign* (any active state→SEEK): a time write.
- *disarm* (any state→IDLE): enable is dropped.

Top module: `tod_clock`

## Requirements
- R1: After reset, the counter holds 0 s / 0 ns, the read snapshot outputs are zero and pulse_out is low.
- R2: With adj_frac equal to zero, the nanosecond field advances by exactly 8 each clock cycle.
- R3: With a positive adj_frac (a signed 32-bit value in 2^-32 ns), the fraction is added every cycle, and each overflow past 2^32 adds 1 ns to that cycle's step. With 0x40000000 (0.25 ns), 400 cycles advance the count by 3300 ns.
- R4: With a negative adj_frac, each borrow takes 1 ns from the step. With 0xC0000000 (-0.25 ns), the first cycle borrows, and 400 cycles advance the count by 3100 ns.
- R5: The nanosecond field never reaches 1 000 000 000. Passing that value subtracts it and increments the seconds field by one.
- R6: A write loads wr_sec and wr_ns on the write edge and clears the fractional accumulator. Counting starts from the loaded values on the next cycle.
- R7: rd_req latches the seconds and nanoseconds held before that edge into rd_sec/rd_ns. Both outputs then stay unchanged until the next rd_req.
- R8: After enable or a time write, the first pulse is on the first boundary after the current time. pulse_out rises one cycle after the counter reaches that boundary.
- R9: With adj_frac zero, successive rising edges are pulse_period/8 cycles apart.
- R10: pulse_out stays high for pulse_width cycles. A width of zero gives pulse_period/16 cycles, which is half the period.
- R11: With a nonzero adj_frac, the spacing between rising edges varies between the two whole cycle counts that bracket period/step. With 0x70000000 and an 800 ns period, the spacing is 94 or 95 cycles.
- R12: While pulse_en is low, pulse_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adj_frac | input | 32 | Signed per-cycle trim, 2^-32 ns units |
| wr_en | input | 1 | Time-load strobe |
| wr_sec | input | 32 | Seconds to load |
| wr_ns | input | 30 | Nanoseconds to load (below 1e9) |
| rd_req | input | 1 | Snapshot strobe |
| rd_sec | output | 32 | Snapshot seconds |
| rd_ns | output | 30 | Snapshot nanoseconds |
| pulse_en | input | 1 | Pulse generator enable |
| pulse_period | input | 30 | Pulse period in ns, a divisor of 1e9, at least 16 |
| pulse_width | input | 32 | High time in cycles; 0 selects half the period |
| pulse_out | output | 1 | Periodic pulse |

## Verification
The assertions assume that every loaded nanosecond value is below one billion. They also assume that the pulse period divides one billion, is at least twice the base step, and only changes while the generator is disabled. Each test therefore loads in-range times and sets the period before raising enable. Each test also keeps the width below the period in cycles, so the retrigger path never interferes with the expected edge positions. Trim values are chosen so that the number of carries or borrows over a window can be worked out by hand.

// File: rtl/tod_pkg.sv
package tod_pkg;
    parameter int SEC_W   = 32;
    parameter int NS_W    = 30;
    parameter int FRAC_W  = 32;
    parameter int WID_W   = 32;
    parameter int BASE_NS = 8;
    parameter int STEP_W  = $clog2(BASE_NS + 2) + 1;
    localparam logic [NS_W:0] NS_PER_SEC = (NS_W+1)'(1_000_000_000);

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_SEEK,
        PS_WAIT,
        PS_HIGH
    } pulse_state_e;
endpackage

// File: rtl/tod_frac_step.sv
module tod_frac_step
    import tod_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic signed [FRAC_W-1:0] adj,
    output logic [STEP_W-1:0]        step_ns
);
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W+1:0] sum;
    logic [1:0]        carry;

    always_comb begin
        sum   = {2'b00, frac_q} + {{2{adj[FRAC_W-1]}}, adj};
        carry = sum[FRAC_W+1:FRAC_W];
        unique case (carry)
            2'b01:   step_ns = STEP_W'(BASE_NS + 1);
            2'b11:   step_ns = STEP_W'(BASE_NS - 1);
            default: step_ns = STEP_W'(BASE_NS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) frac_q <= '0;
        else                 frac_q <= sum[FRAC_W-1:0];
    end

    p_zero_trim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adj == 0) |-> (step_ns == STEP_W'(BASE_NS)));
    p_pos_trim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adj >= 0) |-> (step_ns >= STEP_W'(BASE_NS)));
    p_neg_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adj < 0) |-> (step_ns <= STEP_W'(BASE_NS)));
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_ns,
    input  logic              wr_en,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [NS_W-1:0]   wr_ns,
    input  logic              rd_req,
    output logic [SEC_W-1:0]  cur_sec,
    output logic [NS_W-1:0]   cur_ns,
    output logic [SEC_W-1:0]  rd_sec,
    output logic [NS_W-1:0]   rd_ns
);
    logic [NS_W:0] ns_sum;
    logic          wrap;

    always_comb begin
        ns_sum = {1'b0, cur_ns} + (NS_W+1)'(step_ns);
        wrap   = (ns_sum >= NS_PER_SEC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sec <= '0;
            cur_ns  <= '0;
        end else if (wr_en) begin
            cur_sec <= wr_sec;
            cur_ns  <= wr_ns;
        end else if (wrap) begin
            cur_sec <= cur_sec + 1'b1;
            cur_ns  <= NS_W'(ns_sum - NS_PER_SEC);
        end else begin
            cur_ns  <= ns_sum[NS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sec <= '0;
            rd_ns  <= '0;
        end else if (rd_req) begin
            rd_sec <= cur_sec;
            rd_ns  <= cur_ns;
        end
    end

    p_ns_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cur_ns} < NS_PER_SEC));
    p_sec_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((cur_sec == $past(cur_sec)) || (cur_sec == $past(cur_sec) + 1'b1)));
    p_write_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cur_sec == $past(wr_sec)) && (cur_ns == $past(wr_ns))));
    p_snapshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ($stable(rd_sec) && $stable(rd_ns)));
endmodule

// File: rtl/tod_pulse_fsm.sv
module tod_pulse_fsm
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             realign,
    input  logic [SEC_W-1:0] realign_sec,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [NS_W-1:0]  cur_ns,
    input  logic [NS_W-1:0]  period,
    input  logic [WID_W-1:0] width,
    output logic             pulse_out
);
    pulse_state_e     state_q, state_d;
    logic [SEC_W-1:0] tgt_sec_q;
    logic [NS_W-1:0]  tgt_ns_q;
    logic [WID_W-1:0] cnt_q;
    logic [WID_W-1:0] width_eff;
    logic [NS_W:0]    tgt_sum;
    logic             crossed;
    logic             load_cnt;

    always_comb begin
        crossed = (cur_sec > tgt_sec_q) ||
                  ((cur_sec == tgt_sec_q) && (cur_ns >= tgt_ns_q));
        tgt_sum = {1'b0, tgt_ns_q} + {1'b0, period};
        if (width != '0)
            width_eff = width;
        else if ((period / NS_W'(2 * BASE_NS)) != '0)
            width_eff = WID_W'(period / NS_W'(2 * BASE_NS));
        else
            width_eff = WID_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (en)                state_d = PS_SEEK;
            PS_SEEK: if (!crossed)          state_d = PS_WAIT;
            PS_WAIT: if (crossed)           state_d = PS_HIGH;
            PS_HIGH: if (crossed)           state_d = PS_HIGH;
                     else if (cnt_q == '0)  state_d = PS_WAIT;
            default:                        state_d = PS_IDLE;
        endcase
        if (!en)
            state_d = PS_IDLE;
        else if (realign)
            state_d = PS_SEEK;
        load_cnt = (state_d == PS_HIGH) && crossed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_sec_q <= '0;
            tgt_ns_q  <= '0;
            cnt_q     <= '0;
        end else begin
            if (en && realign) begin
                tgt_sec_q <= realign_sec;
                tgt_ns_q  <= '0;
            end else if (en && state_q == PS_IDLE) begin
                tgt_sec_q <= cur_sec;
                tgt_ns_q  <= '0;
            end else if (en && state_q != PS_IDLE && crossed) begin
                if (tgt_sum >= NS_PER_SEC) begin
                    tgt_sec_q <= tgt_sec_q + 1'b1;
                    tgt_ns_q  <= NS_W'(tgt_sum - NS_PER_SEC);
                end else begin
                    tgt_ns_q  <= tgt_sum[NS_W-1:0];
                end
            end
            if (load_cnt)                cnt_q <= width_eff - 1'b1;
            else if (state_q == PS_HIGH && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        pulse_out = (state_q == PS_HIGH);
    end

    p_fire_on_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_WAIT && crossed && en && !realign) |=> pulse_out);
    p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && cnt_q != '0 && en && !realign) |=> pulse_out);
    p_rise_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(en));
    p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_out);
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [FRAC_W-1:0] adj_frac,
    input  logic                     wr_en,
    input  logic [SEC_W-1:0]         wr_sec,
    input  logic [NS_W-1:0]          wr_ns,
    input  logic                     rd_req,
    output logic [SEC_W-1:0]         rd_sec,
    output logic [NS_W-1:0]          rd_ns,
    input  logic                     pulse_en,
    input  logic [NS_W-1:0]          pulse_period,
    input  logic [WID_W-1:0]         pulse_width,
    output logic                     pulse_out
);
    logic [STEP_W-1:0] step_ns;
    logic [SEC_W-1:0]  cur_sec;
    logic [NS_W-1:0]   cur_ns;

    tod_frac_step u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_en),
        .adj     (adj_frac),
        .step_ns (step_ns)
    );

    tod_time_reg u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_ns (step_ns),
        .wr_en   (wr_en),
        .wr_sec  (wr_sec),
        .wr_ns   (wr_ns),
        .rd_req  (rd_req),
        .cur_sec (cur_sec),
        .cur_ns  (cur_ns),
        .rd_sec  (rd_sec),
        .rd_ns   (rd_ns)
    );

    tod_pulse_fsm u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (pulse_en),
        .realign     (wr_en),
        .realign_sec (wr_sec),
        .cur_sec     (cur_sec),
        .cur_ns      (cur_ns),
        .period      (pulse_period),
        .width       (pulse_width),
        .pulse_out   (pulse_out)
    );
endmodule

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [31:0] adj_frac = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_sec = '0;
    logic [29:0]        wr_ns = '0;
    logic               rd_req = 1'b0;
    logic [31:0]        rd_sec;
    logic [29:0]        rd_ns;
    logic               pulse_en = 1'b0;
    logic [29:0]        pulse_period = 30'd800;
    logic [31:0]        pulse_width = '0;
    logic               pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tod_clock dut_i (
        .clk(clk), .rst_n(rst_n), .adj_frac(adj_frac),
        .wr_en(wr_en), .wr_sec(wr_sec), .wr_ns(wr_ns),
        .rd_req(rd_req), .rd_sec(rd_sec), .rd_ns(rd_ns),
        .pulse_en(pulse_en), .pulse_period(pulse_period),
        .pulse_width(pulse_width), .pulse_out(pulse_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_time(input logic [31:0] s, input logic [29:0] ns);
        @(negedge clk);
        wr_en = 1'b1; wr_sec = s; wr_ns = ns;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_after(input int n, output logic [31:0] s, output logic [29:0] ns);
        repeat (n) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        s = rd_sec; ns = rd_ns;
    endtask

    // cycles counted from the negedge after the call until pulse_out is high
    task automatic cycles_to_high(input int limit, output int c);
        c = 0;
        while (!pulse_out && c < limit) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic high_length(input int limit, output int c);
        c = 0;
        while (pulse_out && c < limit) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic t_reset_r1();
        check(rd_sec == 0, "R1 rd_sec", rd_sec, 0);
        check(rd_ns == 0, "R1 rd_ns", rd_ns, 0);
        check(pulse_out == 0, "R1 pulse_out", pulse_out, 0);
    endtask

    task automatic t_nominal_r2();
        logic [31:0] s; logic [29:0] ns;
        adj_frac = '0;
        write_time(32'd5, 30'd1000);
        read_after(0, s, ns);
        check(ns == 1000 && s == 5, "R2 zero cycles", ns, 1000);
        write_time(32'd5, 30'd1000);
        read_after(50, s, ns);
        check(ns == 1400, "R2 fifty cycles", ns, 1400);
    endtask

    task automatic t_pos_trim_r3();
        logic [31:0] s; logic [29:0] ns;
        adj_frac = 32'sh4000_0000;
        write_time(32'd1, 30'd2000);
        read_after(400, s, ns);
        check(ns == 2000 + 3300, "R3 positive trim", ns, 5300);
    endtask

    task automatic t_neg_trim_r4();
        logic [31:0] s; logic [29:0] ns;
        adj_frac = 32'shC000_0000;
        write_time(32'd1, 30'd2000);
        read_after(400, s, ns);
        check(ns == 2000 + 3100, "R4 negative trim", ns, 5100);
        adj_frac = '0;
    endtask

    task automatic t_wrap_r5();
        logic [31:0] s; logic [29:0] ns;
        adj_frac = '0;
        write_time(32'd9, 30'd999_999_984);
        read_after(5, s, ns);
        check(s == 10, "R5 seconds carry", s, 10);
        check(ns == 24, "R5 ns wrap", ns, 24);
    endtask

    task automatic t_write_clear_r6();
        logic [31:0] s; logic [29:0] ns;
        adj_frac = 32'sh4000_0000;
        write_time(32'd1, 30'd100);
        @(negedge clk);
        write_time(32'd2, 30'd500);
        read_after(3, s, ns);
        check(s == 2, "R6 seconds loaded", s, 2);
        check(ns == 524, "R6 fraction cleared", ns, 524);
        adj_frac = '0;
    endtask

    task automatic t_snapshot_r7();
        logic [31:0] s; logic [29:0] ns;
        write_time(32'd4, 30'd800);
        read_after(10, s, ns);
        check(ns == 880, "R7 snapshot value", ns, 880);
        repeat (20) @(negedge clk);
        check(rd_ns == 880 && rd_sec == 4, "R7 snapshot held", rd_ns, 880);
    endtask

    task automatic t_first_edge_r8();
        int c;
        adj_frac = '0;
        pulse_period = 30'd1_000_000_000;
        pulse_width = 32'd5;
        @(negedge clk);
        pulse_en = 1'b1;
        write_time(32'd7, 30'd999_999_200);
        cycles_to_high(300, c);
        check(c == 101, "R8 first edge cycle", c, 101);
        high_length(300, c);
        check(c == 5, "R10 programmed width", c, 5);
        pulse_en = 1'b0;
    endtask

    task automatic t_period_r9();
        int c;
        adj_frac = '0;
        pulse_period = 30'd800;
        pulse_width = '0;
        @(negedge clk);
        pulse_en = 1'b1;
        write_time(32'd3, 30'd0);
        cycles_to_high(300, c);
        check(c == 101, "R8 boundary 800", c, 101);
        high_length(300, c);
        check(c == 50, "R10 default half period", c, 50);
        cycles_to_high(300, c);
        check(c == 50, "R9 spacing 100 cycles", c + 50, 100);
        pulse_width = 32'd7;
        high_length(300, c);
        cycles_to_high(300, c);
        high_length(300, c);
        check(c == 7, "R10 width after change", c, 7);
    endtask

    task automatic t_disable_r12();
        int hi = 0;
        @(negedge clk);
        pulse_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pulse_out) hi++;
        end
        check(hi == 0, "R12 low while disabled", hi, 0);
    endtask

    task automatic t_dither_r11();
        int c, h, iv;
        int n94 = 0, n95 = 0, bad = 0;
        adj_frac = 32'sh7000_0000;
        pulse_period = 30'd800;
        pulse_width = 32'd3;
        @(negedge clk);
        pulse_en = 1'b1;
        write_time(32'd6, 30'd0);
        cycles_to_high(300, c);
        for (int k = 0; k < 20; k++) begin
            high_length(300, h);
            cycles_to_high(300, c);
            iv = h + c;
            if (iv == 94) n94++;
            else if (iv == 95) n95++;
            else bad++;
        end
        check(bad == 0, "R11 spacing outside 94..95", bad, 0);
        check(n94 > 0, "R11 short spacing seen", n94, 1);
        check(n95 > 0, "R11 long spacing seen", n95, 1);
        pulse_en = 1'b0;
        adj_frac = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_nominal_r2();
        t_pos_trim_r3();
        t_neg_trim_r4();
        t_wrap_r5();
        t_write_clear_r6();
        t_snapshot_r7();
        t_first_edge_r8();
        t_period_r9();
        t_disable_r12();
        t_dither_r11();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule